// File: doc/BRIEF.md
# Iterative 32-bit Signed/Unsigned Integer Divider

This block divides one 32-bit integer by another in a fixed eight-cycle run. The host presents a dividend, a divisor and a signed-mode select and pulses a load strobe. The operand holding registers capture those values in one clock. A one-cycle start pulse then launches the division. The datapath resolves four quotient bits per cycle with a chain of four restoring subtract-and-compare steps, so the 32-bit quotient is complete after eight iterations.

Signed mode works on operand magnitudes and fixes the signs at the end. The quotient truncates toward zero and the remainder follows the dividend's sign. A zero divisor raises an error flag. Completion is still reported on the normal schedule, with a defined quotient and remainder.

The control is a two-state machine. **ST_IDLE** waits for a start. The transition *accept* (start while idle) clears the flags, samples the operands and enters **ST_RUN**. In ST_RUN the transition *step* (iteration count below seven) stays in ST_RUN. The transition *finish* (count equals seven) writes the results, raises the completion flag and returns to ST_IDLE. A start seen in ST_RUN takes no transition.

Top module: `int_divider`

## Requirements
- R1: After reset, busy_o, done_o and dz_o are 0, and quotient_o and remainder_o are 0.
- R2: A cycle with ld_i high captures dividend_i, divisor_i and signed_i. A start_i in the same cycle as ld_i divides the values being loaded.
- R3: A start_i seen in ST_IDLE is accepted. busy_o is high from the next cycle and done_o is low. done_o rises exactly 8 clock edges after the accepting edge, and busy_o falls on that same edge.
- R4: With signed_i=0, quotient_o is the unsigned floor of dividend/divisor, and remainder_o is dividend minus quotient times divisor.
- R5: With signed_i=1, operands are two's complement and the quotient truncates toward zero. It is negative when the operand signs differ. The remainder takes the dividend's sign.
- R6: Signed 0x80000000 divided by 0xFFFFFFFF (-1) gives quotient 0x80000000 and remainder 0.
- R7: A divisor of zero sets dz_o together with done_o, on the normal 8-cycle schedule. quotient_o is then 0xFFFFFFFF and remainder_o equals the dividend, in either mode.
- R8: A start_i while busy_o is high is ignored. The running division keeps its completion cycle and its result.
- R9: An accepted start clears done_o and dz_o on the next cycle. Between completions, quotient_o and remainder_o hold their values.
- R10: A load during a running division does not change that division's result. The loaded values are used by the next start that carries no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| ld_i | input | 1 | Operand load strobe |
| dividend_i | input | 32 | Dividend to load |
| divisor_i | input | 32 | Divisor to load |
| signed_i | input | 1 | 1 selects two's complement division |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Result valid |
| dz_o | output | 1 | Last division had a zero divisor |
| quotient_o | output | 32 | Quotient |
| remainder_o | output | 32 | Remainder |

## Verification
Two things can fall in one cycle: an operand load and a start, or a load or start during a run. The bench drives ld_i and start_i together and expects the freshly presented operands to be divided. It also loads new operands and pulses start midway through a run. It then checks that the run still ends on its eighth edge with the old result. A following start without load must divide the operands loaded mid-run.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        trial = {rem_i, quo_i[W-1]};
        diff  = trial - {1'b0, den_i};
        fits  = (trial >= {1'b0, den_i});
        rem_o = fits ? diff[W-1:0] : trial[W-1:0];
        quo_o = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/div_stage.sv
module div_stage #(
    parameter int W = 32,
    parameter int K = 4
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W-1:0] rem_c [K+1];
    logic [W-1:0] quo_c [K+1];

    assign rem_c[0] = rem_i;
    assign quo_c[0] = quo_i;

    for (genvar k = 0; k < K; k++) begin : g_step
        div_step #(.W(W)) u_step (
            .rem_i (rem_c[k]),
            .quo_i (quo_c[k]),
            .den_i (den_i),
            .rem_o (rem_c[k+1]),
            .quo_o (quo_c[k+1])
        );
    end

    assign rem_o = rem_c[K];
    assign quo_o = quo_c[K];
endmodule

// File: rtl/div_sign_in.sv
module div_sign_in #(
    parameter int W = 32
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    input  logic         sgn_i,
    output logic [W-1:0] num_mag_o,
    output logic [W-1:0] den_mag_o,
    output logic         neg_q_o,
    output logic         neg_r_o
);
    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg   = sgn_i & num_i[W-1];
        den_neg   = sgn_i & den_i[W-1];
        num_mag_o = num_neg ? (~num_i + 1'b1) : num_i;
        den_mag_o = den_neg ? (~den_i + 1'b1) : den_i;
        neg_q_o   = num_neg ^ den_neg;
        neg_r_o   = num_neg;
    end
endmodule

// File: rtl/div_sign_out.sv
module div_sign_out #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] raw_num_i,
    input  logic         neg_q_i,
    input  logic         neg_r_i,
    input  logic         dz_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    always_comb begin
        if (dz_i) begin
            quo_o = '1;
            rem_o = raw_num_i;
        end else begin
            quo_o = neg_q_i ? (~quo_i + 1'b1) : quo_i;
            rem_o = neg_r_i ? (~rem_i + 1'b1) : rem_i;
        end
    end
endmodule

// File: rtl/int_divider.sv
module int_divider
    import div_pkg::*;
#(
    parameter int WIDTH          = 32,
    parameter int BITS_PER_CYCLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  logic             signed_i,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             dz_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);
    localparam int CYCLES = WIDTH / BITS_PER_CYCLE;
    localparam int CNT_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    div_state_e state_q, state_d;

    // operand holding registers
    logic [WIDTH-1:0] opa_q, opb_q;
    logic             sgn_q;

    // working registers
    logic [WIDTH-1:0] w_rem, w_quo, w_den, w_raw;
    logic             w_negq, w_negr, w_dz;
    logic [CNT_W-1:0] cnt_q;

    // effective operands (same-cycle load forwards)
    logic [WIDTH-1:0] eff_a, eff_b;
    logic             eff_s;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic             negq_n, negr_n;
    logic [WIDTH-1:0] st_rem, st_quo;
    logic [WIDTH-1:0] fin_q, fin_r;
    logic             accept, last_step;

    assign eff_a     = ld_i ? dividend_i : opa_q;
    assign eff_b     = ld_i ? divisor_i  : opb_q;
    assign eff_s     = ld_i ? signed_i   : sgn_q;
    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_step = (state_q == ST_RUN) && (cnt_q == LAST);
    assign busy_o    = (state_q == ST_RUN);

    div_sign_in #(.W(WIDTH)) u_sign_in (
        .num_i     (eff_a),
        .den_i     (eff_b),
        .sgn_i     (eff_s),
        .num_mag_o (mag_a),
        .den_mag_o (mag_b),
        .neg_q_o   (negq_n),
        .neg_r_o   (negr_n)
    );

    div_stage #(.W(WIDTH), .K(BITS_PER_CYCLE)) u_stage (
        .rem_i (w_rem),
        .quo_i (w_quo),
        .den_i (w_den),
        .rem_o (st_rem),
        .quo_o (st_quo)
    );

    div_sign_out #(.W(WIDTH)) u_sign_out (
        .quo_i     (st_quo),
        .rem_i     (st_rem),
        .raw_num_i (w_raw),
        .neg_q_i   (w_negq),
        .neg_r_i   (w_negr),
        .dz_i      (w_dz),
        .quo_o     (fin_q),
        .rem_o     (fin_r)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, step, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            sgn_q <= 1'b0;
        end else if (ld_i) begin
            opa_q <= dividend_i;
            opb_q <= divisor_i;
            sgn_q <= signed_i;
        end
    end

    // iterative datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_rem  <= '0;
            w_quo  <= '0;
            w_den  <= '0;
            w_raw  <= '0;
            w_negq <= 1'b0;
            w_negr <= 1'b0;
            w_dz   <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            w_rem  <= '0;
            w_quo  <= mag_a;
            w_den  <= mag_b;
            w_raw  <= eff_a;
            w_negq <= negq_n;
            w_negr <= negr_n;
            w_dz   <= (eff_b == '0);
            cnt_q  <= '0;
        end else if (state_q == ST_RUN) begin
            w_rem  <= st_rem;
            w_quo  <= st_quo;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            dz_o        <= 1'b0;
            quotient_o  <= '0;
            remainder_o <= '0;
        end else if (accept) begin
            done_o <= 1'b0;
            dz_o   <= 1'b0;
        end else if (last_step) begin
            done_o      <= 1'b1;
            dz_o        <= w_dz;
            quotient_o  <= fin_q;
            remainder_o <= fin_r;
        end
    end

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !done_o));

    // R3
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

    // R3
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q == LAST) |=> (!busy_o && done_o));

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R7
    dz_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dz_o |-> (done_o && quotient_o == '1));

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(w_raw) && $stable(w_den)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

// File: tb/sim_int_divider.sv
module sim_int_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        signed_i = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, dz_o;
    logic [31:0] quotient_o, remainder_o;

    int nchk = 0;
    int nerr = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    int_divider u0 (
        .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .dividend_i(dividend_i),
        .divisor_i(divisor_i), .signed_i(signed_i), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .dz_o(dz_o),
        .quotient_o(quotient_o), .remainder_o(remainder_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] a, input logic [31:0] b, input bit s,
                         output logic [31:0] q, output logic [31:0] r);
        longint sa, sb;
        if (b == 0) begin
            q = 32'hFFFF_FFFF;
            r = a;
        end else if (!s) begin
            q = a / b;
            r = a % b;
        end else begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            q = 32'(sa / sb);
            r = 32'(sa % sb);
        end
    endtask

    // drive a division; returns at the negedge after the accepting edge
    task automatic launch(input logic [31:0] a, input logic [31:0] b,
                          input bit s, input bit same);
        @(negedge clk);
        dividend_i = a; divisor_i = b; signed_i = s; ld_i = 1'b1;
        if (!same) begin
            @(negedge clk);
            ld_i = 1'b0;
        end
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ld_i = 1'b0;
    endtask

    task automatic wait_result(input string req, input logic [31:0] a,
                               input logic [31:0] b, input bit s);
        logic [31:0] eq, er;
        model(a, b, s, eq, er);
        chk(busy_o === 1'b1 && done_o === 1'b0, "R3", "busy after accept", {30'd0, busy_o, done_o}, 32'h2);
        repeat (7) @(negedge clk);
        chk(done_o === 1'b0, "R3", "done early", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        chk(done_o === 1'b1 && busy_o === 1'b0, "R3", "done on 8th edge", {30'd0, busy_o, done_o}, 32'h1);
        chk(quotient_o === eq, req, "quotient", quotient_o, eq);
        chk(remainder_o === er, req, "remainder", remainder_o, er);
        chk(dz_o === (b == 0), "R7", "dz flag", {31'd0, dz_o}, {31'd0, b == 0});
    endtask

    task automatic one(input string req, input logic [31:0] a, input logic [31:0] b, input bit s);
        launch(a, b, s, 1'b0);
        wait_result(req, a, b, s);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(busy_o === 0 && done_o === 0 && dz_o === 0, "R1", "flags in reset",
            {29'd0, busy_o, done_o, dz_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(quotient_o === 0 && remainder_o === 0, "R1", "results after reset",
            quotient_o | remainder_o, 32'd0);
    endtask

    task automatic t_unsigned;
        one("R4", 32'd100, 32'd7, 1'b0);
        one("R4", 32'hFFFF_FFFF, 32'd1, 1'b0);
        one("R4", 32'hDEAD_BEEF, 32'h0001_2345, 1'b0);
        one("R4", 32'd5, 32'd9, 1'b0);
        one("R4", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_signed;
        one("R5", 32'hFFFF_FF9C, 32'd7, 1'b1);   // -100 / 7
        one("R5", 32'd100, 32'hFFFF_FFF9, 1'b1); // 100 / -7
        one("R5", 32'hFFFF_FF9C, 32'hFFFF_FFF9, 1'b1);
        one("R5", 32'h7FFF_FFFF, 32'd3, 1'b1);
        one("R6", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_dz;
        one("R7", 32'h1234_5678, 32'd0, 1'b0);
        one("R7", 32'hF000_0001, 32'd0, 1'b1);
    endtask

    task automatic t_same_cycle;
        launch(32'd1000, 32'd33, 1'b0, 1'b1);
        wait_result("R2", 32'd1000, 32'd33, 1'b0);
    endtask

    task automatic t_busy_overlap;
        logic [31:0] eq, er;
        launch(32'd77777, 32'd13, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        dividend_i = 32'hFFFF_FF00; divisor_i = 32'd16; signed_i = 1'b1;
        ld_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        ld_i = 1'b0; start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(done_o === 1'b0, "R8", "no early done", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        chk(done_o === 1'b1, "R8", "original schedule kept", {31'd0, done_o}, 32'd1);
        model(32'd77777, 32'd13, 1'b0, eq, er);
        chk(quotient_o === eq, "R10", "running result unaffected", quotient_o, eq);
        chk(remainder_o === er, "R10", "running remainder unaffected", remainder_o, er);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_result("R10", 32'hFFFF_FF00, 32'd16, 1'b1);
    endtask

    task automatic t_clear_hold;
        logic [31:0] hq, hr;
        one("R7", 32'd42, 32'd0, 1'b0);
        hq = quotient_o; hr = remainder_o;
        repeat (3) @(negedge clk);
        chk(quotient_o === hq && remainder_o === hr, "R9", "results hold while idle",
            quotient_o, hq);
        launch(32'd50, 32'd5, 1'b0, 1'b0);
        chk(done_o === 1'b0 && dz_o === 1'b0, "R9", "flags cleared by start",
            {30'd0, done_o, dz_o}, 32'd0);
        wait_result("R9", 32'd50, 32'd5, 1'b0);
    endtask

    initial begin
        t_reset();
        t_unsigned();
        t_signed();
        t_dz();
        t_same_cycle();
        t_busy_overlap();
        t_clear_hold();
        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog run did not finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule